// File: doc/BRIEF.md
# JTAG Debug Transport

This block connects a JTAG port to a debug module. A 16-state TAP controller runs on the test clock. It steps through the instruction and data paths, and a 5-bit instruction register selects one of four data registers: an identification word, a control/status word, a debug-access register and a 1-bit bypass register. Data and instructions shift in and out least significant bit first, and the TDO pin presents the low bit of the active shift path.

A scan of the debug-access register carries an address, a 32-bit data word and a 2-bit operation. At Update-DR the block turns a read or write operation into one request on a valid/ready channel. It then waits for a single response on a companion channel. Only one request may be outstanding at a time. The block keeps a sticky status that records a failed access or a scan that arrived too early. That status is shown in the operation field of every capture and in a field of the control/status word. While the status is non-zero, the block ignores new operations. Two bits of the control/status word recover from errors. The soft bit only clears the sticky status. The hard bit abandons the pending access and clears all transport state.

The debug-module side runs on the same test clock. The response channel never stalls, so a late response to an abandoned access is absorbed and has no effect.

Top module: `jdbg_transport`

## Requirements
- R1: The TAP follows the standard 16-state graph, and five clocks with TMS high reach Test-Logic-Reset from any state. In that state the instruction register loads 0x01. Capture-IR loads 5'b00001, so that pattern shifts out first, least significant bit first.
- R2: With instruction 0x01, Capture-DR loads a 32-bit word. Bits 31:28 hold the version parameter, bits 27:12 the part parameter, bits 11:1 the maker parameter, and bit 0 is 1.
- R3: With instruction 0x10, Capture-DR loads a 32-bit word. Bits 14:12 hold the idle-cycle hint, bits 11:10 the sticky status, bits 9:4 the address width and bits 3:0 the value 1. All other bits read 0.
- R4: With instruction 0x11, the register is ABITS+34 bits long. Bits 1:0 are the operation (0 no-op, 1 read, 2 write, 3 ignored), bits 33:2 are data and the top ABITS bits are the address. An update with a read or write, while nothing is outstanding and the status is 0, issues exactly one request carrying those fields. req_valid, req_addr and req_op then stay stable until req_ready is seen.
- R5: Capture of the access register returns the address of the last request above the data of the last read response, with the status code in bits 1:0.
- R6: A capture or an update of the access register while a request is outstanding sets the status to 3 (busy). The capture returns 3 in its operation field, and no new request is issued.
- R7: While the status is non-zero, access-register updates issue no request.
- R8: A response with rsp_err set makes the status 2 (failed). Status value 1 is never produced.
- R9: An update of the control/status register with bit 16 set clears the status to 0 and keeps any outstanding request pending.
- R10: An update of the control/status register with bit 17 set drops the outstanding request. It also clears the status and the stored address and data, and a response that arrives afterwards is ignored.
- R11: Any instruction other than 0x01, 0x10 and 0x11 selects a 1-bit bypass register that captures 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; also clocks the debug-module channels |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by the debug module |
| req_addr | output | ABITS | Request address |
| req_data | output | 32 | Write data |
| req_op | output | 2 | 1 read, 2 write |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Always 1; responses are never stalled |
| rsp_data | input | 32 | Read data |
| rsp_err | input | 1 | Access failed |

## Verification
A wrong TAP state or wrong instruction decode shows up in the same scan: the captured bits that shift out on TDO no longer match the selected register's layout. A lost pending flag or a lost sticky status shows up at the next capture of the access register. That capture returns the wrong code in its operation field, and in the other direction a request appears on req_valid within a few clocks of an update that should have been blocked, or fails to appear after one that should not. Abandoned or late responses are caught one scan later, through the stored data field.

// File: rtl/jdbg_pkg.sv
package jdbg_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_DR_SEL, TS_DR_CAP, TS_DR_SHIFT, TS_DR_EXIT1, TS_DR_PAUSE, TS_DR_EXIT2, TS_DR_UPD,
      TS_IR_SEL, TS_IR_CAP, TS_IR_SHIFT, TS_IR_EXIT1, TS_IR_PAUSE, TS_IR_EXIT2, TS_IR_UPD
   } tap_state_e;

   localparam int IR_W = 5;

   localparam logic [IR_W-1:0] IR_IDCODE = 5'h01;
   localparam logic [IR_W-1:0] IR_CTRL   = 5'h10;
   localparam logic [IR_W-1:0] IR_ACCESS = 5'h11;
   localparam logic [IR_W-1:0] IR_BYPASS = 5'h1f;
   localparam logic [IR_W-1:0] IR_CAPVAL = 5'b00001;

   localparam logic [1:0] OP_NOP = 2'd0;
   localparam logic [1:0] OP_RD  = 2'd1;
   localparam logic [1:0] OP_WR  = 2'd2;

   localparam logic [1:0] ST_OK   = 2'd0;
   localparam logic [1:0] ST_FAIL = 2'd2;
   localparam logic [1:0] ST_BUSY = 2'd3;

   localparam int CTL_SOFT_BIT = 16;
   localparam int CTL_HARD_BIT = 17;

endpackage

// File: rtl/jdbg_tap.sv
module jdbg_tap
   import jdbg_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      unique case (state)
         TS_RESET:    nxt = tms ? TS_RESET    : TS_IDLE;
         TS_IDLE:     nxt = tms ? TS_DR_SEL   : TS_IDLE;
         TS_DR_SEL:   nxt = tms ? TS_IR_SEL   : TS_DR_CAP;
         TS_DR_CAP:   nxt = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
         TS_DR_SHIFT: nxt = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
         TS_DR_EXIT1: nxt = tms ? TS_DR_UPD   : TS_DR_PAUSE;
         TS_DR_PAUSE: nxt = tms ? TS_DR_EXIT2 : TS_DR_PAUSE;
         TS_DR_EXIT2: nxt = tms ? TS_DR_UPD   : TS_DR_SHIFT;
         TS_DR_UPD:   nxt = tms ? TS_DR_SEL   : TS_IDLE;
         TS_IR_SEL:   nxt = tms ? TS_RESET    : TS_IR_CAP;
         TS_IR_CAP:   nxt = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
         TS_IR_SHIFT: nxt = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
         TS_IR_EXIT1: nxt = tms ? TS_IR_UPD   : TS_IR_PAUSE;
         TS_IR_PAUSE: nxt = tms ? TS_IR_EXIT2 : TS_IR_PAUSE;
         TS_IR_EXIT2: nxt = tms ? TS_IR_UPD   : TS_IR_SHIFT;
         TS_IR_UPD:   nxt = tms ? TS_DR_SEL   : TS_IDLE;
         default:     nxt = TS_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= TS_RESET;
      else         state <= nxt;
   end

endmodule

// File: rtl/jdbg_ir.sv
module jdbg_ir
   import jdbg_pkg::*;
(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir,
   output logic            sh_lsb
);

   logic [IR_W-1:0] sh;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir <= IR_IDCODE;
         sh <= '0;
      end else begin
         unique case (state)
            TS_RESET:    ir <= IR_IDCODE;
            TS_IR_CAP:   sh <= IR_CAPVAL;
            TS_IR_SHIFT: sh <= {tdi, sh[IR_W-1:1]};
            TS_IR_UPD:   ir <= sh;
            default: ;
         endcase
      end
   end

   assign sh_lsb = sh[0];

endmodule

// File: rtl/jdbg_dmi.sv
module jdbg_dmi
   import jdbg_pkg::*;
#(
   parameter int ABITS = 7,
   localparam int DW   = ABITS + 34
)(
   input  logic             tck,
   input  logic             trst_n,
   input  logic             cap_acc,
   input  logic             upd_acc,
   input  logic             soft_clr,
   input  logic             hard_clr,
   input  logic [DW-1:0]    upd_word,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [ABITS-1:0] req_addr,
   output logic [31:0]      req_data,
   output logic [1:0]       req_op,
   input  logic             rsp_valid,
   input  logic [31:0]      rsp_data,
   input  logic             rsp_err,
   output logic [1:0]       stat,
   output logic             pending,
   output logic [ABITS-1:0] last_addr,
   output logic [31:0]      last_data
);

   logic [1:0] op_in;
   logic       accept, rsp_done, early;

   assign op_in    = upd_word[1:0];
   assign accept   = upd_acc && (stat == ST_OK) && !pending && (op_in == OP_RD || op_in == OP_WR);
   assign rsp_done = pending && !req_valid && rsp_valid;
   assign early    = (cap_acc || upd_acc) && pending;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         req_valid <= 1'b0;
         req_addr  <= '0;
         req_data  <= '0;
         req_op    <= OP_NOP;
         pending   <= 1'b0;
         stat      <= ST_OK;
         last_addr <= '0;
         last_data <= '0;
      end else if (hard_clr) begin
         req_valid <= 1'b0;
         req_addr  <= '0;
         req_data  <= '0;
         req_op    <= OP_NOP;
         pending   <= 1'b0;
         stat      <= ST_OK;
         last_addr <= '0;
         last_data <= '0;
      end else begin
         if (req_valid && req_ready) req_valid <= 1'b0;
         if (accept) begin
            req_valid <= 1'b1;
            req_addr  <= upd_word[DW-1:34];
            req_data  <= upd_word[33:2];
            req_op    <= op_in;
            last_addr <= upd_word[DW-1:34];
            pending   <= 1'b1;
         end
         if (rsp_done) begin
            pending <= 1'b0;
            if (req_op == OP_RD) last_data <= rsp_data;
         end
         if (soft_clr)             stat <= ST_OK;
         else if (stat == ST_OK) begin
            if (early)                    stat <= ST_BUSY;
            else if (rsp_done && rsp_err) stat <= ST_FAIL;
         end
      end
   end

endmodule

// File: rtl/jdbg_transport.sv
module jdbg_transport
   import jdbg_pkg::*;
#(
   parameter int          ABITS      = 7,
   parameter logic [3:0]  ID_VERSION = 4'h1,
   parameter logic [15:0] ID_PART    = 16'h0000,
   parameter logic [10:0] ID_MANUF   = 11'h000,
   parameter int          IDLE_CYC   = 1,
   parameter bit          TDO_FALL   = 1'b0,
   localparam int         DW         = ABITS + 34,
   localparam int         LW         = $clog2(DW)
)(
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   output logic             tdo,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [ABITS-1:0] req_addr,
   output logic [31:0]      req_data,
   output logic [1:0]       req_op,
   input  logic             rsp_valid,
   output logic             rsp_ready,
   input  logic [31:0]      rsp_data,
   input  logic             rsp_err
);

   if (ABITS < 1 || ABITS > 32) begin : g_bad_abits
      $error("ABITS must lie in 1..32");
   end
   if (IDLE_CYC < 0 || IDLE_CYC > 7) begin : g_bad_idle
      $error("IDLE_CYC must fit in three bits");
   end

   tap_state_e      tap_st;
   logic [IR_W-1:0] ir_q;
   logic            ir_lsb;
   logic [DW-1:0]   dr_sh, dr_nx, cap_word;
   logic [LW-1:0]   msb_idx;
   logic            cap_acc, upd_acc, upd_ctl, soft_clr, hard_clr;
   logic [1:0]      dmi_stat, cap_op;
   logic            dmi_pending;
   logic [ABITS-1:0] last_addr;
   logic [31:0]     last_data, id_word, ctl_word;
   logic            tdo_raw;

   jdbg_tap u_tap (.tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_st));

   jdbg_ir u_ir (.tck(tck), .trst_n(trst_n), .state(tap_st), .tdi(tdi),
                 .ir(ir_q), .sh_lsb(ir_lsb));

   assign cap_acc  = (tap_st == TS_DR_CAP) && (ir_q == IR_ACCESS);
   assign upd_acc  = (tap_st == TS_DR_UPD) && (ir_q == IR_ACCESS);
   assign upd_ctl  = (tap_st == TS_DR_UPD) && (ir_q == IR_CTRL);
   assign soft_clr = upd_ctl && dr_sh[CTL_SOFT_BIT];
   assign hard_clr = upd_ctl && dr_sh[CTL_HARD_BIT];

   jdbg_dmi #(.ABITS(ABITS)) u_dmi (
      .tck(tck), .trst_n(trst_n), .cap_acc(cap_acc), .upd_acc(upd_acc),
      .soft_clr(soft_clr), .hard_clr(hard_clr), .upd_word(dr_sh),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_data(req_data), .req_op(req_op), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_err(rsp_err), .stat(dmi_stat),
      .pending(dmi_pending), .last_addr(last_addr), .last_data(last_data));

   assign rsp_ready = 1'b1;

   assign id_word  = {ID_VERSION, ID_PART, ID_MANUF, 1'b1};
   assign ctl_word = {14'd0, 2'b00, 1'b0, 3'(IDLE_CYC), dmi_stat, 6'(ABITS), 4'd1};
   assign cap_op   = (dmi_pending && dmi_stat == ST_OK) ? ST_BUSY : dmi_stat;

   always_comb begin
      unique case (ir_q)
         IR_IDCODE: begin cap_word = {{(DW-32){1'b0}}, id_word};  msb_idx = LW'(31);     end
         IR_CTRL:   begin cap_word = {{(DW-32){1'b0}}, ctl_word}; msb_idx = LW'(31);     end
         IR_ACCESS: begin cap_word = {last_addr, last_data, cap_op}; msb_idx = LW'(DW-1); end
         default:   begin cap_word = '0;                          msb_idx = '0;          end
      endcase
   end

   always_comb begin
      dr_nx          = dr_sh >> 1;
      dr_nx[msb_idx] = tdi;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                     dr_sh <= '0;
      else if (tap_st == TS_DR_CAP)    dr_sh <= cap_word;
      else if (tap_st == TS_DR_SHIFT)  dr_sh <= dr_nx;
   end

   assign tdo_raw = (tap_st == TS_IR_SHIFT) ? ir_lsb : dr_sh[0];

   if (TDO_FALL) begin : g_tdo_fall
      logic tdo_q;
      always_ff @(negedge tck or negedge trst_n) begin
         if (!trst_n) tdo_q <= 1'b0;
         else         tdo_q <= tdo_raw;
      end
      assign tdo = tdo_q;
   end else begin : g_tdo_comb
      assign tdo = tdo_raw;
   end

endmodule

// File: rtl/jdbg_transport_chk.sv
module jdbg_transport_chk
   import jdbg_pkg::*;
#(
   parameter int ABITS = 7
)(
   input logic             tck,
   input logic             trst_n,
   input tap_state_e       state,
   input logic [IR_W-1:0]  ir,
   input logic             req_valid,
   input logic             req_ready,
   input logic [ABITS-1:0] req_addr,
   input logic [1:0]       req_op,
   input logic             pending,
   input logic [1:0]       stat,
   input logic             hard,
   input logic             cap_acc
);

   p_tlr_ir_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_RESET) |=> (ir == IR_IDCODE));

   p_req_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
      (req_valid && !req_ready && !hard) |=> (req_valid && $stable(req_addr) && $stable(req_op)));

   p_req_single_r4: assert property (@(posedge tck) disable iff (!trst_n)
      req_valid |-> pending);

   p_req_op_r4: assert property (@(posedge tck) disable iff (!trst_n)
      req_valid |-> (req_op == OP_RD || req_op == OP_WR));

   p_busy_set_r6: assert property (@(posedge tck) disable iff (!trst_n)
      (cap_acc && pending && stat == ST_OK) |=> (stat == ST_BUSY));

   p_no_code1_r8: assert property (@(posedge tck) disable iff (!trst_n)
      stat != 2'd1);

   p_hard_clear_r10: assert property (@(posedge tck) disable iff (!trst_n)
      hard |=> (!pending && !req_valid && stat == ST_OK));

endmodule

bind jdbg_transport jdbg_transport_chk #(.ABITS(ABITS)) u_chk (
   .tck(tck), .trst_n(trst_n), .state(tap_st), .ir(ir_q),
   .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
   .req_op(req_op), .pending(dmi_pending), .stat(dmi_stat),
   .hard(hard_clr), .cap_acc(cap_acc));

// File: tb/sim_jdbg_transport.sv
module sim_jdbg_transport;
   import jdbg_pkg::*;

   localparam int          AB   = 7;
   localparam int          DW   = AB + 34;
   localparam logic [3:0]  VER  = 4'h2;
   localparam logic [15:0] PART = 16'hB7E5;
   localparam logic [10:0] MAN  = 11'h2A3;
   localparam int          IDLE = 1;
   localparam logic [31:0] ID_EXP  = {VER, PART, MAN, 1'b1};
   localparam logic [31:0] CTL_EXP = (32'(IDLE) << 12) | (32'(AB) << 4) | 32'd1;

   logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic tdo;
   logic req_valid, req_ready, rsp_valid, rsp_ready, rsp_err;
   logic [AB-1:0] req_addr;
   logic [31:0] req_data, rsp_data;
   logic [1:0] req_op;

   always #10 tck = ~tck;

   jdbg_transport #(.ABITS(AB), .ID_VERSION(VER), .ID_PART(PART), .ID_MANUF(MAN),
                    .IDLE_CYC(IDLE)) u0 (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_data(req_data), .req_op(req_op), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err));

   int checks = 0, errors = 0;
   int lat = 2;

   typedef struct packed { logic [1:0] op; logic [AB-1:0] a; logic [31:0] d; } exp_t;
   exp_t q[$];
   logic [31:0] mem [0:(1<<AB)-1];

   function automatic logic [31:0] memval(int i);
      return 32'h1000_0000 + 32'(i) * 32'h0101_0103;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(logic m, logic d);
      @(negedge tck); tms = m; tdi = d;
   endtask

   task automatic idle(int n);
      repeat (n) step(1'b0, 1'b0);
   endtask

   task automatic tap_reset();
      repeat (5) step(1'b1, 1'b0);
      step(1'b0, 1'b0);
   endtask

   task automatic scan_ir(logic [IR_W-1:0] din, output logic [63:0] dout);
      dout = '0;
      step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
      for (int i = 0; i < IR_W; i++) begin
         @(negedge tck); dout[i] = tdo; tms = (i == IR_W-1); tdi = din[i];
      end
      step(1'b1, 1'b0); step(1'b0, 1'b0);
   endtask

   task automatic scan_dr(int w, logic [63:0] din, output logic [63:0] dout);
      dout = '0;
      step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
      for (int i = 0; i < w; i++) begin
         @(negedge tck); dout[i] = tdo; tms = (i == w-1); tdi = din[i];
      end
      step(1'b1, 1'b0); step(1'b0, 1'b0);
   endtask

   // driver: pushes the request the design should emit, then scans
   task automatic dmi(logic [1:0] op, logic [AB-1:0] a, logic [31:0] d, bit expect_req,
                      output logic [63:0] cap);
      exp_t e;
      if (expect_req) begin
         e.op = op; e.a = a; e.d = d;
         q.push_back(e);
      end
      scan_dr(DW, 64'({a, d, op}), cap);
   endtask

   // monitor and responder
   initial begin
      exp_t e;
      logic [1:0] r_op;
      logic [AB-1:0] r_a;
      logic [31:0] r_d, r_rd;
      for (int i = 0; i < (1<<AB); i++) mem[i] = memval(i);
      req_ready = 1'b1; rsp_valid = 1'b0; rsp_data = '0; rsp_err = 1'b0;
      forever begin
         @(negedge tck);
         if (req_valid === 1'b1) begin
            r_op = req_op; r_a = req_addr; r_d = req_data;
            if (q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R7 unexpected request actual op %0d addr %h expected none", r_op, r_a);
            end else begin
               e = q.pop_front();
               chk("R4 request op", 64'(r_op), 64'(e.op));
               chk("R4 request addr", 64'(r_a), 64'(e.a));
               if (e.op == OP_WR) chk("R4 request data", 64'(r_d), 64'(e.d));
            end
            r_rd = mem[r_a];
            if (r_op == OP_WR) mem[r_a] = r_d;
            @(posedge tck);
            repeat (lat) @(negedge tck);
            @(negedge tck);
            rsp_valid = 1'b1; rsp_data = r_rd; rsp_err = (r_a == '1);
            @(negedge tck);
            rsp_valid = 1'b0; rsp_err = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge tck);
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] v;
      repeat (3) @(negedge tck);
      trst_n = 1'b1;
      tap_reset();

      // R1/R2: reset selects identification register
      scan_dr(32, 64'h0, v);
      chk("R2 idcode after reset", v, 64'(ID_EXP));
      scan_ir(IR_CTRL, v);
      chk("R1 ir capture pattern", v, 64'(IR_CAPVAL));
      scan_dr(32, 64'h0, v);
      chk("R3 ctrl word", v, 64'(CTL_EXP));

      // R11: bypass, explicit and unknown codes
      scan_ir(IR_BYPASS, v);
      scan_dr(8, 64'hB6, v);
      chk("R11 bypass 0x1f", v, 64'({8'hB6, 1'b0}) & 64'hFF);
      scan_ir(5'h05, v);
      scan_dr(8, 64'h4D, v);
      chk("R11 bypass unknown", v, 64'({8'h4D, 1'b0}) & 64'hFF);

      // R1: Test-Logic-Reset restores identification instruction
      scan_ir(IR_ACCESS, v);
      tap_reset();
      scan_dr(32, 64'h0, v);
      chk("R1 ir reset by tms", v, 64'(ID_EXP));

      // R4/R5: write then read round trip
      scan_ir(IR_ACCESS, v);
      lat = 3;
      dmi(OP_WR, 7'h12, 32'hDEAD_BEEF, 1, v);
      chk("R5 status before write", v & 64'h3, 64'(ST_OK));
      idle(lat + 8);
      dmi(OP_RD, 7'h12, 32'h0, 1, v);
      idle(lat + 8);
      dmi(OP_NOP, '0, 32'h0, 0, v);
      chk("R5 read back written", v, 64'({7'h12, 32'hDEAD_BEEF, ST_OK}));

      lat = 0;
      dmi(OP_RD, 7'h05, 32'h0, 1, v);
      idle(8);
      dmi(OP_NOP, '0, 32'h0, 0, v);
      chk("R5 read short latency", v, 64'({7'h05, memval(5), ST_OK}));

      // R6/R7/R9: early rescan and soft clear
      lat = 600;
      dmi(OP_RD, 7'h09, 32'h0, 1, v);
      dmi(OP_NOP, '0, 32'h0, 0, v);
      chk("R6 busy on early capture", v & 64'h3, 64'(ST_BUSY));
      dmi(OP_RD, 7'h0A, 32'h0, 0, v);
      chk("R7 busy persists", v & 64'h3, 64'(ST_BUSY));
      scan_ir(IR_CTRL, v);
      scan_dr(32, 64'h1_0000, v);
      chk("R3 ctrl shows busy", (v >> 10) & 64'h3, 64'(ST_BUSY));
      scan_dr(32, 64'h0, v);
      chk("R9 soft clear status", (v >> 10) & 64'h3, 64'(ST_OK));
      scan_ir(IR_ACCESS, v);
      dmi(OP_NOP, '0, 32'h0, 0, v);
      chk("R9 pending kept", v & 64'h3, 64'(ST_BUSY));
      idle(650);
      scan_ir(IR_CTRL, v);
      scan_dr(32, 64'h1_0000, v);
      scan_ir(IR_ACCESS, v);
      dmi(OP_NOP, '0, 32'h0, 0, v);
      chk("R9 slow read lands", v, 64'({7'h09, memval(9), ST_OK}));

      // R8/R7: failed access and ignored write
      lat = 2;
      dmi(OP_RD, 7'h7F, 32'h0, 1, v);
      idle(12);
      dmi(OP_WR, 7'h03, 32'h0000_1234, 0, v);
      chk("R8 failed status", v & 64'h3, 64'(ST_FAIL));
      idle(10);
      scan_ir(IR_CTRL, v);
      scan_dr(32, 64'h1_0000, v);
      chk("R8 ctrl shows failed", (v >> 10) & 64'h3, 64'(ST_FAIL));
      scan_ir(IR_ACCESS, v);
      dmi(OP_RD, 7'h03, 32'h0, 1, v);
      idle(12);
      dmi(OP_NOP, '0, 32'h0, 0, v);
      chk("R7 write while failed ignored", v, 64'({7'h03, memval(3), ST_OK}));

      // R10: hard reset abandons pending read
      lat = 600;
      dmi(OP_RD, 7'h14, 32'h0, 1, v);
      scan_ir(IR_CTRL, v);
      scan_dr(32, 64'h2_0000, v);
      scan_dr(32, 64'h0, v);
      chk("R10 ctrl after hard", v, 64'(CTL_EXP));
      scan_ir(IR_ACCESS, v);
      dmi(OP_NOP, '0, 32'h0, 0, v);
      chk("R10 cleared access", v, 64'h0);
      idle(650);
      dmi(OP_NOP, '0, 32'h0, 0, v);
      chk("R10 late response ignored", v, 64'h0);
      lat = 1;
      dmi(OP_RD, 7'h15, 32'h0, 1, v);
      idle(10);
      dmi(OP_NOP, '0, 32'h0, 0, v);
      chk("R10 works after hard", v, 64'({7'h15, memval(21), ST_OK}));

      chk("R4 all requests seen", 64'(q.size()), 64'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule